// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Write Mode

This block is a one-port memory in which both reads and writes take effect on the rising clock edge. Read data always comes out of an output register, so a word appears on `dout` one edge after its address is presented. A clock enable gates every action of the block. A write enable turns an enabled cycle into a store. A synchronous set/reset loads the output register with a fixed value.

A parameter chooses what the output register shows on an edge that performs a write. It can show the newly written data, the word that was overwritten, or the value it already held. The output register has its own power-up value and reset value, and these can differ. The array can also be preloaded from a parameter. This lets the same memory serve as a lookup table, a scratch buffer, or a read-modify-write store without extra logic around it.

Top module: `spram_wmode`

## Requirements
- R1: Before any enabled clock edge has acted on it, `dout` equals the parameter `OUT_INIT`.
- R2: On an edge with `en`=1, `we`=0 and `srst`=0, `dout` takes the word stored at `addr`. The value is visible after that edge.
- R3: On an edge with `en`=1 and `we`=1, the word at `addr` is replaced by `din`. A later read of that address returns it.
- R4: With `WMODE` set to write-first, a write edge (with `srst`=0) puts `din` on `dout`.
- R5: With `WMODE` set to read-first, a write edge (with `srst`=0) puts the word that was stored at `addr` before the write on `dout`.
- R6: With `WMODE` set to no-change, a write edge (with `srst`=0) leaves `dout` unchanged.
- R7: On an edge with `en`=1 and `srst`=1, `dout` becomes the parameter `OUT_RST`, whatever `we` is.
- R8: A write with `srst`=1 and `en`=1 still stores `din` in the array.
- R9: On an edge with `en`=0, the array is not written, `srst` has no effect and `dout` holds its value.
- R10: At start-up, word i of the array holds bits [i*DATA_W +: DATA_W] of the parameter `MEM_INIT`.
- R11: If `WMODE` is not overridden, the block behaves as write-first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action happens on its rising edge |
| en | input | 1 | Clock enable; when low the block does nothing |
| we | input | 1 | Write enable; stores `din` at `addr` when `en` is high |
| srst | input | 1 | Synchronous set/reset of the output register (active high) |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |

## Verification
The hardest case to reach is a reset that coincides with a write. The output then shows only the reset value, so the write can be seen only through a later read of the same address. The stimulus therefore puts a reset-plus-write at an address whose preloaded value is known, then reads that address back. Three copies of the block, one per write mode, receive the same stimulus. Back-to-back writes, overwrites of the same word, and disabled cycles that carry write and reset requests are placed so that each mode's output can be seen to differ from the others.

// File: rtl/spram_wm_pkg.sv
package spram_wm_pkg;

  // What the output register shows on a write edge
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

endpackage

// File: rtl/spram_store.sv
module spram_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH*DATA_W-1:0] MEM_INIT = '0
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] old_word
);

  logic [DATA_W-1:0] mem [DEPTH];

  // R10: preload from the parameter image
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = MEM_INIT[i*DATA_W +: DATA_W];
    end
  end

  // R3 / R8: the store depends only on the gated write, never on reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= din;
  end

  // Word present before this edge's write; the output stage registers it
  assign old_word = mem[addr];

endmodule

// File: rtl/spram_outstage.sv
module spram_outstage
  import spram_wm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter wmode_e WMODE = WM_WRITE_FIRST,
  parameter logic [DATA_W-1:0] OUT_INIT = '0,
  parameter logic [DATA_W-1:0] OUT_RST  = '0
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic              srst,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] old_word,
  output logic [DATA_W-1:0] dout
);

  // R1: power-up value of the output register
  logic [DATA_W-1:0] q = OUT_INIT;
  logic [DATA_W-1:0] wr_view;
  logic [DATA_W-1:0] q_nxt;

  generate
    if (WMODE == WM_WRITE_FIRST) begin : g_wf
      assign wr_view = din;
    end else if (WMODE == WM_READ_FIRST) begin : g_rf
      assign wr_view = old_word;
    end else begin : g_nc
      assign wr_view = q;
    end
  endgenerate

  always_comb begin
    q_nxt = q;
    if (en) begin
      if (srst)    q_nxt = OUT_RST;
      else if (we) q_nxt = wr_view;
      else         q_nxt = old_word;
    end
  end

  always_ff @(posedge clk) q <= q_nxt;

  assign dout = q;

  // Becomes 1 after the first edge so that $past never looks before time zero
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!armed)
    !en |=> $stable(dout));

  // R7
  srst_value_chk: assert property (@(posedge clk) disable iff (!armed)
    en && srst |=> dout == OUT_RST);

  // R2
  read_data_chk: assert property (@(posedge clk) disable iff (!armed)
    en && !we && !srst |=> dout == $past(old_word));

  generate
    if (WMODE == WM_WRITE_FIRST) begin : g_wf_chk
      // R4
      wf_shows_din_chk: assert property (@(posedge clk) disable iff (!armed)
        en && we && !srst |=> dout == $past(din));
    end else if (WMODE == WM_READ_FIRST) begin : g_rf_chk
      // R5
      rf_shows_old_chk: assert property (@(posedge clk) disable iff (!armed)
        en && we && !srst |=> dout == $past(old_word));
    end else begin : g_nc_chk
      // R6
      nc_holds_chk: assert property (@(posedge clk) disable iff (!armed)
        en && we && !srst |=> $stable(dout));
    end
  endgenerate

endmodule

// File: rtl/spram_wmode.sv
module spram_wmode
  import spram_wm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter wmode_e WMODE = WM_WRITE_FIRST,
  parameter logic [DATA_W-1:0] OUT_INIT = '0,
  parameter logic [DATA_W-1:0] OUT_RST  = '0,
  localparam int DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH*DATA_W-1:0] MEM_INIT = '0
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic              srst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] old_word;
  logic              wr_en;

  // R9: a disabled cycle never writes
  assign wr_en = en & we;

  spram_store #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .MEM_INIT(MEM_INIT)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .addr    (addr),
    .din     (din),
    .old_word(old_word)
  );

  spram_outstage #(
    .DATA_W  (DATA_W),
    .WMODE   (WMODE),
    .OUT_INIT(OUT_INIT),
    .OUT_RST (OUT_RST)
  ) u_out (
    .clk     (clk),
    .en      (en),
    .we      (we),
    .srst    (srst),
    .din     (din),
    .old_word(old_word),
    .dout    (dout)
  );

endmodule

// File: tb/spram_wmode_test.sv
`timescale 1ns/1ps
module spram_wmode_test;
  import spram_wm_pkg::*;

  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] P_INIT = 8'hA5;
  localparam logic [DW-1:0] P_RST  = 8'h3C;

  function automatic logic [DW-1:0] init_word(int i);
    return DW'(i * 29) ^ 8'h5A;
  endfunction

  function automatic logic [DEPTH*DW-1:0] mk_image();
    logic [DEPTH*DW-1:0] v;
    for (int i = 0; i < DEPTH; i++) v[i*DW +: DW] = init_word(i);
    return v;
  endfunction

  localparam logic [DEPTH*DW-1:0] IMG = mk_image();

  logic clk = 1'b0;
  logic en = 1'b0, we = 1'b0, srst = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout_wf, dout_rf, dout_nc;

  always #2.5 clk = ~clk;

  // WMODE left at its default (R11)
  spram_wmode #(.DATA_W(DW), .ADDR_W(AW), .OUT_INIT(P_INIT),
                .OUT_RST(P_RST), .MEM_INIT(IMG)) uut (
    .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr), .din(din), .dout(dout_wf));

  spram_wmode #(.DATA_W(DW), .ADDR_W(AW), .WMODE(WM_READ_FIRST), .OUT_INIT(P_INIT),
                .OUT_RST(P_RST), .MEM_INIT(IMG)) uut_rf (
    .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr), .din(din), .dout(dout_rf));

  spram_wmode #(.DATA_W(DW), .ADDR_W(AW), .WMODE(WM_NO_CHANGE), .OUT_INIT(P_INIT),
                .OUT_RST(P_RST), .MEM_INIT(IMG)) uut_nc (
    .clk(clk), .en(en), .we(we), .srst(srst), .addr(addr), .din(din), .dout(dout_nc));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model of the array and of each mode's output
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] e_wf, e_rf, e_nc;
  logic [DEPTH-1:0] m_written = '0;
  logic [DEPTH-1:0] m_rst_written = '0;

  // Stimulus vector: {en, we, srst, addr[3:0], din[7:0]}
  localparam int NV = 17;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 4'h0, 8'h00},  // read preloaded word 0
    {1'b1, 1'b0, 1'b0, 4'h7, 8'hEE},  // read preloaded word 7
    {1'b1, 1'b1, 1'b0, 4'h3, 8'h11},  // write
    {1'b1, 1'b0, 1'b0, 4'h3, 8'h00},  // read back
    {1'b1, 1'b1, 1'b0, 4'h3, 8'h22},  // overwrite: read-first shows 11
    {1'b0, 1'b1, 1'b0, 4'h3, 8'h99},  // disabled write
    {1'b1, 1'b0, 1'b0, 4'h3, 8'h00},  // still 22
    {1'b0, 1'b0, 1'b1, 4'h5, 8'h00},  // disabled reset
    {1'b1, 1'b0, 1'b1, 4'h5, 8'h00},  // reset beats read
    {1'b1, 1'b1, 1'b0, 4'hF, 8'hF0},  // write top word
    {1'b1, 1'b0, 1'b0, 4'hF, 8'h00},
    {1'b1, 1'b1, 1'b0, 4'h0, 8'h01},  // back-to-back writes
    {1'b1, 1'b1, 1'b0, 4'h0, 8'h02},
    {1'b1, 1'b0, 1'b0, 4'h0, 8'h00},
    {1'b1, 1'b0, 1'b0, 4'h9, 8'h00},  // read preloaded word 9
    {1'b1, 1'b1, 1'b1, 4'h9, 8'h77},  // reset with write
    {1'b1, 1'b0, 1'b0, 4'h9, 8'h00}   // write survived reset
  };

  task automatic step(logic s_en, logic s_we, logic s_rst, logic [AW-1:0] s_a, logic [DW-1:0] s_d);
    logic [DW-1:0] old;
    string tag;
    @(negedge clk);
    en = s_en; we = s_we; srst = s_rst; addr = s_a; din = s_d;
    @(posedge clk);
    if (s_en) begin
      old = m_mem[s_a];
      if (s_we) m_mem[s_a] = s_d;
      if (s_rst) begin
        e_wf = P_RST; e_rf = P_RST; e_nc = P_RST;
      end else if (s_we) begin
        e_wf = s_d; e_rf = old;
      end else begin
        e_wf = old; e_rf = old; e_nc = old;
      end
    end
    #1;
    if (!s_en)                        tag = "R9";
    else if (s_rst)                   tag = "R7";
    else if (s_we)                    tag = "write";
    else if (m_rst_written[s_a])      tag = "R8";
    else if (m_written[s_a])          tag = "R3";
    else                              tag = "R10";
    if (tag == "write") begin
      chk("R4+R11 write-first", dout_wf, e_wf);
      chk("R5 read-first", dout_rf, e_rf);
      chk("R6 no-change", dout_nc, e_nc);
    end else begin
      chk({tag, " R2 wf"}, dout_wf, e_wf);
      chk({tag, " R2 rf"}, dout_rf, e_rf);
      chk({tag, " R2 nc"}, dout_nc, e_nc);
    end
    if (s_en && s_we) begin
      m_written[s_a] = 1'b1;
      m_rst_written[s_a] = s_rst;
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = init_word(i);
    e_wf = P_INIT; e_rf = P_INIT; e_nc = P_INIT;
    #1;
    // R1: power-up value before any edge
    chk("R1 wf", dout_wf, P_INIT);
    chk("R1 rf", dout_rf, P_INIT);
    chk("R1 nc", dout_nc, P_INIT);
    // R9: disabled edges leave the power-up value in place
    step(1'b0, 1'b0, 1'b0, 4'h1, 8'h00);
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][11:8], VEC[v][7:0]);
    end
    // Directed: reset with write, then the no-change copy must hold the reset value on a write
    step(1'b1, 1'b1, 1'b1, 4'h2, 8'h44);
    step(1'b1, 1'b1, 1'b0, 4'h2, 8'h55);
    step(1'b1, 1'b0, 1'b0, 4'h2, 8'h00);
    // Disabled write to word 4, then read: preloaded value survives (R9)
    step(1'b0, 1'b1, 1'b1, 4'h4, 8'hCC);
    step(1'b1, 1'b0, 1'b0, 4'h4, 8'h00);
    chk("R9 untouched word", dout_wf, init_word(4));
    wrap_up();
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    wrap_up();
  end

endmodule